// File: doc/BRIEF.md
# Dual-Mode Display Identification Mode Controller

This block owns the access-mode state of a 128-byte identification memory. After reset it is in transmit-only mode: each rising edge of a dedicated stream clock moves a serial output on by one bit, walking the memory from address 0 to 127. Each byte goes out most significant bit first, and the walk wraps around and repeats. A falling edge on the two-wire bus clock moves the block into a transition mode.

In transition mode a pulse counter decides what happens next. Rising edges of the stream clock advance the counter, and every falling edge of the bus clock clears it. When 128 pulses arrive with no bus-clock falling edge, the block returns to transmit-only mode and restarts the stream at the most significant bit of address 0. If the bus slave engine reports a matching control byte first, the block locks into bidirectional mode. Only a reset leaves bidirectional mode. In that mode the stream clock acts only as a write permission.

Both asynchronous clock inputs pass through two-flop synchronisers before edge detection. The memory is read combinationally at the address the block drives.

Top module: `dispid_mode_ctrl`

## Requirements
- R1: Reset state. `mode_o` is 0 (the codes are 0 = transmit-only, 1 = transition, 2 = bidirectional), `mem_addr_o` is 0, `ser_o` equals bit 7 of `mem_rdata_i`, and `wr_en_o` is 0.
- R2: In transmit-only mode, each rising edge of `vclk_i` advances the stream by one bit, from bit 7 down to bit 0 of the current byte. After bit 0 of address a, the stream moves to bit 7 of address a+1, and address 127 wraps to 0.
- R3: A falling edge of `scl_i` in transmit-only mode moves the block to transition mode. Outside transmit-only mode, `ser_o` is held at 1.
- R4: In transition mode, rising edges of `vclk_i` count and do not move the stream position (`mem_addr_o` holds). A falling edge of `scl_i` clears the count.
- R5: The 128th counted `vclk_i` rising edge with no `scl_i` falling edge since the last clear returns the block to transmit-only mode. The stream restarts at bit 7 of address 0.
- R6: A one-cycle `ctrl_match_i` pulse in transition mode moves the block to bidirectional mode. A pulse in transmit-only mode has no effect.
- R7: Bidirectional mode is kept until reset, whatever `vclk_i`, `scl_i` or `ctrl_match_i` do.
- R8: `wr_en_o` is 1 only in bidirectional mode while the synchronised `vclk_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Two-wire bus clock, asynchronous |
| vclk_i | input | 1 | Stream clock, asynchronous |
| ctrl_match_i | input | 1 | One-cycle pulse: control byte recognised |
| mem_rdata_i | input | 8 | Memory byte at `mem_addr_o` |
| mem_addr_o | output | 7 | Stream read address |
| ser_o | output | 1 | Serial stream bit |
| mode_o | output | 2 | Mode code (0/1/2) |
| wr_en_o | output | 1 | Write permission |

## Verification
An edge on `scl_i` or `vclk_i` reaches the state on the third rising clock edge after the input changes: two synchroniser flops and one edge-history flop. `wr_en_o` follows the synchronised level after two edges. A `ctrl_match_i` pulse takes effect at the edge that samples it. The bench changes inputs on falling clock edges and holds every level for four cycles, which is more than all of these delays. It samples the outputs on the falling edge after the hold, so each result is already settled when it is read. The stream and the recovery count are swept across full bytes, the address wrap, and the 127th and 128th pulses.

// File: rtl/dispid_pkg.sv
package dispid_pkg;
    typedef enum logic [1:0] {
        MODE_TX    = 2'd0,
        MODE_TRANS = 2'd1,
        MODE_BIDIR = 2'd2
    } mode_e;
endpackage

// File: rtl/dispid_sync.sv
module dispid_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic lvl_o,
    output logic prev_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], async_i};
        st_d.prev = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o  = st_q.sh[STAGES-1];
    assign prev_o = st_q.prev;
endmodule

// File: rtl/dispid_mode_fsm.sv
module dispid_mode_fsm
    import dispid_pkg::*;
#(
    parameter int RECOVER_PULSES = 128
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  scl_fall_i,
    input  logic  vclk_rise_i,
    input  logic  ctrl_match_i,
    output mode_e mode_o,
    output logic  restart_o
);
    localparam int CNT_W = $clog2(RECOVER_PULSES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RECOVER_PULSES - 1);

    typedef struct packed {
        mode_e            mode;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t st_d, st_q;
    logic restart;

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        unique case (st_q.mode)
            MODE_TX: begin
                if (scl_fall_i) begin
                    st_d.mode = MODE_TRANS;
                    st_d.cnt  = '0;
                end
            end
            MODE_TRANS: begin
                if (ctrl_match_i) begin
                    st_d.mode = MODE_BIDIR;
                    st_d.cnt  = '0;
                end else if (scl_fall_i) begin
                    st_d.cnt = '0;
                end else if (vclk_rise_i) begin
                    if (st_q.cnt == CNT_LAST) begin
                        st_d.mode = MODE_TX;
                        st_d.cnt  = '0;
                        restart   = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                st_d.mode = MODE_BIDIR;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_TX, cnt: '0};
        else        st_q <= st_d;
    end

    assign mode_o    = st_q.mode;
    assign restart_o = restart;

    AST_BIDIR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode == MODE_BIDIR |=> st_q.mode == MODE_BIDIR); // R7
    AST_NO_DIRECT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode == MODE_TX |=> st_q.mode != MODE_BIDIR); // R6
    AST_CNT_IDLE_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode == MODE_TX |-> st_q.cnt == '0); // R5
    AST_FALLBACK_TO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> st_q.mode == MODE_TX); // R5
endmodule

// File: rtl/dispid_tx_stream.sv
module dispid_tx_stream #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       active_i,
    input  logic                       adv_i,
    input  logic                       restart_i,
    input  logic [DATA_W-1:0]          rdata_i,
    output logic [$clog2(DEPTH)-1:0]   addr_o,
    output logic                       ser_o
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int BIT_W  = $clog2(DATA_W);
    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(DEPTH - 1);
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(DATA_W - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BIT_W-1:0]  bitn;
    } pos_t;

    pos_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d = '0;
        end else if (adv_i) begin
            if (st_q.bitn == BIT_LAST) begin
                st_d.bitn = '0;
                st_d.addr = (st_q.addr == ADDR_LAST) ? '0 : st_q.addr + 1'b1;
            end else begin
                st_d.bitn = st_q.bitn + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.addr;
    assign ser_o  = active_i ? rdata_i[BIT_LAST - st_q.bitn] : 1'b1;

    AST_RESTART_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (st_q.addr == '0 && st_q.bitn == '0)); // R5
    AST_FROZEN_OFF_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i && !restart_i) |=> $stable(st_q)); // R4
endmodule

// File: rtl/dispid_mode_ctrl.sv
module dispid_mode_ctrl
    import dispid_pkg::*;
#(
    parameter int DEPTH          = 128,
    parameter int DATA_W         = 8,
    parameter int RECOVER_PULSES = 128,
    parameter int SYNC_STAGES    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      vclk_i,
    input  logic                      ctrl_match_i,
    input  logic [DATA_W-1:0]         mem_rdata_i,
    output logic [$clog2(DEPTH)-1:0]  mem_addr_o,
    output logic                      ser_o,
    output logic [1:0]                mode_o,
    output logic                      wr_en_o
);
    logic  scl_lvl, scl_prev, vclk_lvl, vclk_prev;
    logic  scl_fall, vclk_rise, restart;
    mode_e mode;

    dispid_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .async_i(scl_i),
        .lvl_o(scl_lvl), .prev_o(scl_prev)
    );

    dispid_sync #(.STAGES(SYNC_STAGES)) u_vclk_sync (
        .clk(clk), .rst_n(rst_n), .async_i(vclk_i),
        .lvl_o(vclk_lvl), .prev_o(vclk_prev)
    );

    assign scl_fall  = scl_prev & ~scl_lvl;
    assign vclk_rise = ~vclk_prev & vclk_lvl;

    dispid_mode_fsm #(.RECOVER_PULSES(RECOVER_PULSES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_fall_i(scl_fall), .vclk_rise_i(vclk_rise),
        .ctrl_match_i(ctrl_match_i),
        .mode_o(mode), .restart_o(restart)
    );

    dispid_tx_stream #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_stream (
        .clk(clk), .rst_n(rst_n),
        .active_i(mode == MODE_TX),
        .adv_i(vclk_rise && mode == MODE_TX),
        .restart_i(restart),
        .rdata_i(mem_rdata_i),
        .addr_o(mem_addr_o),
        .ser_o(ser_o)
    );

    assign mode_o  = mode;
    assign wr_en_o = (mode == MODE_BIDIR) & vclk_lvl;

    AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> mode_o == 2'd2); // R8
    AST_SER_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd0 |-> ser_o); // R3
endmodule

// File: tb/dispid_mode_ctrl_tb.sv
module dispid_mode_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       vclk = 1'b0;
    logic       ctrl = 1'b0;
    logic [7:0] rdata;
    logic [6:0] addr;
    logic       ser;
    logic [1:0] mode;
    logic       wr_en;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] memb(input logic [6:0] a);
        return 8'({1'b0, a} * 8'd37 + 8'd11) ^ {1'b0, a};
    endfunction

    assign rdata = memb(addr);

    dispid_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .vclk_i(vclk),
        .ctrl_match_i(ctrl), .mem_rdata_i(rdata), .mem_addr_o(addr),
        .ser_o(ser), .mode_o(mode), .wr_en_o(wr_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic vpulse();
        vclk = 1'b1; wait_n(4);
        vclk = 1'b0; wait_n(4);
    endtask

    task automatic sfall();
        scl = 1'b0; wait_n(4);
        scl = 1'b1; wait_n(4);
    endtask

    task automatic match();
        ctrl = 1'b1; wait_n(1);
        ctrl = 1'b0; wait_n(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        chk("R1 mode", 32'(mode), 0);
        chk("R1 addr", 32'(addr), 0);
        chk("R1 ser", 32'(ser), 32'(memb(7'd0) >> 7) & 1);
        chk("R1 wr_en", 32'(wr_en), 0);

        // R6 match pulse in transmit-only has no effect
        match();
        chk("R6 ignored in tx", 32'(mode), 0);

        // R2 sweep of 129 bytes + wrap
        for (int p = 0; p < 1032; p++) begin
            chk("R2 addr", 32'(addr), 32'((p / 8) % 128));
            chk("R2 bit", 32'(ser), 32'((memb(7'((p / 8) % 128)) >> (7 - p % 8)) & 1));
            if (p == 0) begin
                vclk = 1'b1; wait_n(4);
                chk("R8 no write in tx", 32'(wr_en), 0);
                vclk = 1'b0; wait_n(4);
            end else begin
                vpulse();
            end
        end
        chk("R2 wrap addr", 32'(addr), 1);

        // R3 enter transition
        sfall();
        chk("R3 mode", 32'(mode), 1);
        chk("R3 ser idle", 32'(ser), 1);

        // R4 count, clear, frozen stream
        for (int i = 0; i < 127; i++) vpulse();
        chk("R4 still transition", 32'(mode), 1);
        chk("R4 addr frozen", 32'(addr), 1);
        sfall();
        for (int i = 0; i < 127; i++) vpulse();
        chk("R4 cleared count", 32'(mode), 1);

        // R5 128th pulse returns and restarts
        vpulse();
        chk("R5 mode", 32'(mode), 0);
        chk("R5 addr", 32'(addr), 0);
        chk("R5 msb", 32'(ser), 32'(memb(7'd0) >> 7) & 1);
        vpulse();
        chk("R5 next bit", 32'(ser), 32'(memb(7'd0) >> 6) & 1);

        // R6 lock into bidirectional
        sfall();
        for (int i = 0; i < 5; i++) vpulse();
        chk("R6 pre", 32'(mode), 1);
        match();
        chk("R6 bidir", 32'(mode), 2);

        // R7 sticky, R8 write permission
        for (int i = 0; i < 200; i++) vpulse();
        sfall(); sfall(); sfall();
        match();
        chk("R7 sticky", 32'(mode), 2);
        chk("R7 ser idle", 32'(ser), 1);
        vclk = 1'b1; wait_n(4);
        chk("R8 wr high", 32'(wr_en), 1);
        vclk = 1'b0; wait_n(4);
        chk("R8 wr low", 32'(wr_en), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule